// File: doc/BRIEF.md
# Bus Address Tenure Controller

This block runs the address phase of a split-transaction processor bus. On the master side it takes a request through a valid/ready handshake. Each request carries a 32-bit physical address and a burst flag. The block then opens an address tenure: it pulses a one-cycle transfer-start strobe, raises a bus-busy indication, enables the address drivers and puts the address on the bus. It keeps that address unchanged until the address acknowledge arrives. In the cycle after the acknowledge it releases the bus. The output pins are not pulled high on release. The output register simply keeps its last value.

On the snooping side the block watches the transfer-start line of other masters. It samples the incoming address only in the cycle in which that strobe is high. It presents the sampled address together with a one-cycle snoop-valid pulse. The block's own transfer start is never captured as a snoop.

The bidirectional address pins are modelled as separate output and input buses with an output enable. The bus keeper or pad logic outside the block resolves them.

Top module: `addr_tenure_ctl`

## Requirements
- R1: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when no tenure is in progress, so it is low from the transfer-start cycle through the acknowledge cycle.
- R2: In the cycle after acceptance, `ts_o`, `abb_o` and `a_oe` rise together and `a_out` carries the requested address.
- R3: `ts_o` is high for exactly one cycle per tenure and only while `abb_o` is high. `abb_o` stays high from the transfer-start cycle through the cycle in which `aack_i` is sampled high.
- R4: `a_out` does not change from the transfer-start cycle through the acknowledge cycle. An acknowledge in the transfer-start cycle itself ends the tenure.
- R5: In the cycle after `aack_i` is sampled high during a tenure, `a_oe` and `abb_o` are low and `req_ready` is high.
- R6: On release there is no precharge drive. `a_out` keeps the last driven address until the next tenure starts.
- R7: With `req_burst` = 1 the driven address has bits [2:0] forced to 0 (double-word aligned). With `req_burst` = 0 all 32 bits are driven as requested.
- R8: When `ts_i` is high and `ts_o` is low, `a_in` is sampled. In the next cycle `snp_valid` is high for one cycle and `snp_addr` equals the sampled value.
- R9: `a_in` is ignored in every other cycle, including cycles where `ts_i` is high while `ts_o` is high. `snp_addr` holds its value and `snp_valid` stays low.
- R10: A synchronous active-high `rst` drives `ts_o`, `abb_o`, `a_oe` and `snp_valid` low, `req_ready` high, and `a_out` and `snp_addr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master request present |
| req_ready | output | 1 | Request can be accepted (no tenure in progress) |
| req_addr | input | 32 | Physical address of the request |
| req_burst | input | 1 | Request is a burst; forces double-word alignment |
| ts_o | output | 1 | Transfer-start strobe driven by this master |
| abb_o | output | 1 | Address bus busy, held for the own tenure |
| aack_i | input | 1 | Address acknowledge |
| a_out | output | 32 | Address pins, output value |
| a_oe | output | 1 | Address pin output enable |
| ts_i | input | 1 | Transfer-start strobe seen from another master |
| a_in | input | 32 | Address pins, input value |
| snp_valid | output | 1 | One-cycle pulse: a snooped address was captured |
| snp_addr | output | 32 | Last snooped address |

## Verification
The assertions assume that the acknowledge belongs to the block's own tenure: only an `aack_i` seen while `abb_o` is high is expected to end one. They also assume reset is held for more than one cycle, so that history-based checks start from cleared registers. The stimulus raises the acknowledge only while the reference model has a tenure open, and it holds reset for three cycles at start and around every mid-run reset. Snoop strobes and address noise are deliberately sent at all times, including while the block's own strobe is high, because the block must reject them by itself.

// File: rtl/atd_pkg.sv
package atd_pkg;
    localparam int ADDR_W     = 32;
    localparam int ALIGN_BITS = 3;

    typedef enum logic [1:0] {
        TEN_IDLE  = 2'd0,
        TEN_START = 2'd1,
        TEN_HOLD  = 2'd2
    } ten_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              burst;
    } ten_req_t;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } snoop_cap_t;

    function automatic logic tenure_open(input ten_state_e s);
        return s != TEN_IDLE;
    endfunction
endpackage

// File: rtl/atd_align.sv
module atd_align #(
    parameter int AW = atd_pkg::ADDR_W,
    parameter int AB = atd_pkg::ALIGN_BITS
) (
    input  logic [AW-1:0] addr_in,
    input  logic          burst,
    output logic [AW-1:0] addr_out
);
    generate
        if (AB == 0) begin : g_none
            logic unused_burst;
            assign unused_burst = burst;
            assign addr_out = addr_in;
        end else begin : g_mask
            localparam logic [AW-1:0] LOW_MASK = AW'((1 << AB) - 1);
            assign addr_out = burst ? (addr_in & ~LOW_MASK) : addr_in;
        end
    endgenerate
endmodule

// File: rtl/atd_master.sv
module atd_master
    import atd_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int AB = ALIGN_BITS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_burst,
    input  logic          aack_i,
    output logic          ts_o,
    output logic          abb_o,
    output logic [AW-1:0] a_out,
    output logic          a_oe
);
    ten_state_e    state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] aligned;
    logic          burst_q;
    logic          accept;

    atd_align #(.AW(AW), .AB(AB)) u_align (
        .addr_in  (req_addr),
        .burst    (req_burst),
        .addr_out (aligned)
    );

    assign accept = req_valid && (state_q == TEN_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TEN_IDLE:  if (accept) state_d = TEN_START;
            TEN_START: state_d = aack_i ? TEN_IDLE : TEN_HOLD;
            TEN_HOLD:  if (aack_i) state_d = TEN_IDLE;
            default:   state_d = TEN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TEN_IDLE;
            addr_q  <= '0;
            burst_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= aligned;
                burst_q <= req_burst;
            end
        end
    end

    assign req_ready = (state_q == TEN_IDLE);
    assign ts_o      = (state_q == TEN_START);
    assign abb_o     = tenure_open(state_q);
    assign a_oe      = tenure_open(state_q);
    assign a_out     = addr_q;

    p_ts_single_r3: assert property (@(posedge clk) disable iff (rst)
        ts_o |=> !ts_o);
    p_ts_under_busy_r3: assert property (@(posedge clk) disable iff (rst)
        ts_o |-> abb_o);
    p_hold_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (abb_o && !ts_o) |-> $stable(a_out));
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (abb_o && aack_i) |=> (!a_oe && !abb_o && req_ready));
    p_ready_r1: assert property (@(posedge clk) disable iff (rst)
        abb_o |-> !req_ready);
    p_no_precharge_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(a_oe) |-> $stable(a_out));
    p_burst_align_r7: assert property (@(posedge clk) disable iff (rst)
        (a_oe && burst_q && AB > 0) |-> (a_out[0] == 1'b0));
endmodule

// File: rtl/atd_snoop.sv
module atd_snoop
    import atd_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ts_i,
    input  logic          own_ts,
    input  logic [AW-1:0] a_in,
    output logic          snp_valid,
    output logic [AW-1:0] snp_addr
);
    snoop_cap_t cap_q;
    logic       take;

    assign take = ts_i && !own_ts;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q.valid <= take;
            if (take) cap_q.addr <= a_in;
        end
    end

    assign snp_valid = cap_q.valid;
    assign snp_addr  = cap_q.addr;

    p_snoop_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> $past(ts_i && !own_ts));
    p_snoop_value_r8: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> (snp_addr == $past(a_in)));
    p_snoop_ignore_r9: assert property (@(posedge clk) disable iff (rst)
        !snp_valid |-> $stable(snp_addr));
endmodule

// File: rtl/addr_tenure_ctl.sv
module addr_tenure_ctl
    import atd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_burst,
    output logic              ts_o,
    output logic              abb_o,
    input  logic              aack_i,
    output logic [ADDR_W-1:0] a_out,
    output logic              a_oe,
    input  logic              ts_i,
    input  logic [ADDR_W-1:0] a_in,
    output logic              snp_valid,
    output logic [ADDR_W-1:0] snp_addr
);
    logic own_ts;

    atd_master #(.AW(ADDR_W), .AB(ALIGN_BITS)) u_master (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_burst (req_burst),
        .aack_i    (aack_i),
        .ts_o      (own_ts),
        .abb_o     (abb_o),
        .a_out     (a_out),
        .a_oe      (a_oe)
    );

    assign ts_o = own_ts;

    atd_snoop #(.AW(ADDR_W)) u_snoop (
        .clk       (clk),
        .rst       (rst),
        .ts_i      (ts_i),
        .own_ts    (own_ts),
        .a_in      (a_in),
        .snp_valid (snp_valid),
        .snp_addr  (snp_addr)
    );

    p_snoop_not_own_r9: assert property (@(posedge clk) disable iff (rst)
        (ts_o && ts_i) |=> !snp_valid);
endmodule

// File: tb/addr_tenure_ctl_test.sv
module addr_tenure_ctl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_burst = 1'b0;
    logic        ts_o, abb_o, a_oe, snp_valid;
    logic        aack_i = 1'b0;
    logic        ts_i = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] a_out, snp_addr;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    addr_tenure_ctl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_burst(req_burst), .ts_o(ts_o), .abb_o(abb_o),
        .aack_i(aack_i), .a_out(a_out), .a_oe(a_oe), .ts_i(ts_i), .a_in(a_in),
        .snp_valid(snp_valid), .snp_addr(snp_addr)
    );

    // Behavioural reference: 0 = idle, 1 = start cycle, 2 = holding
    int          m_st = 0;
    logic [31:0] m_addr = '0;
    logic        m_burst = 1'b0;
    logic        m_snp_v = 1'b0;
    logic [31:0] m_snp_addr = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_addr = '0; m_burst = 1'b0;
            m_snp_v = 1'b0; m_snp_addr = '0;
        end else begin
            m_snp_v = ts_i && (m_st != 1);
            if (m_snp_v) m_snp_addr = a_in;
            if (m_st == 0) begin
                if (req_valid) begin
                    m_addr  = req_burst ? (req_addr & 32'hFFFF_FFF8) : req_addr;
                    m_burst = req_burst;
                    m_st    = 1;
                end
            end else begin
                m_st = aack_i ? 0 : 2;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3 ts_o", 32'(ts_o), 32'(m_st == 1));
        chk("R3 abb_o", 32'(abb_o), 32'(m_st != 0));
        chk("R5 a_oe", 32'(a_oe), 32'(m_st != 0));
        chk("R1 req_ready", 32'(req_ready), 32'(m_st == 0));
        if (m_st == 1)      chk("R2 a_out at start", a_out, m_addr);
        else if (m_st == 2) chk("R4 a_out held", a_out, m_addr);
        else                chk("R6 a_out after release", a_out, m_addr);
        if (m_st != 0 && m_burst) chk("R7 burst alignment", {29'd0, a_out[2:0]}, 32'd0);
        chk("R8 snp_valid", 32'(snp_valid), 32'(m_snp_v));
        chk("R9 snp_addr", snp_addr, m_snp_addr);
    endtask

    task automatic step(input logic rv, input logic [31:0] ra, input logic rb,
                        input logic ak, input logic ti, input logic [31:0] ain);
        @(negedge clk);
        compare_all();
        req_valid = rv; req_addr = ra; req_burst = rb;
        aack_i = ak; ts_i = ti; a_in = ain;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ts_o", 32'(ts_o), 0);
        chk("R10 abb_o", 32'(abb_o), 0);
        chk("R10 a_oe", 32'(a_oe), 0);
        chk("R10 snp_valid", 32'(snp_valid), 0);
        chk("R10 req_ready", 32'(req_ready), 1);
        chk("R10 a_out", a_out, 0);
        chk("R10 snp_addr", snp_addr, 0);
        rst = 1'b0;

        // R2 R4 R5: single beat, acknowledge after two hold cycles
        step(1, 32'h1234_5677, 0, 0, 0, 32'hDEAD_0001);
        step(0, 32'h0, 0, 0, 0, 32'hDEAD_0002);
        step(0, 32'h0, 0, 0, 0, 32'hDEAD_0003);
        step(0, 32'h0, 0, 1, 0, 32'hDEAD_0004);
        step(0, 32'h0, 0, 0, 0, 32'hDEAD_0005);
        // R6: bus released, a_out keeps last address
        step(0, 32'h0, 0, 0, 0, 32'h0);
        // R7: burst request with low bits set, acknowledge in start cycle (R4)
        step(1, 32'hABCD_EF17, 1, 0, 0, 32'h0);
        step(0, 32'h0, 0, 1, 0, 32'h0);
        step(0, 32'h0, 0, 0, 0, 32'h0);
        // R1: back-to-back requests, valid held high
        step(1, 32'h0000_1001, 0, 0, 0, 32'h0);
        step(1, 32'h0000_2002, 0, 1, 0, 32'h0);
        step(1, 32'h0000_3003, 1, 0, 0, 32'h0);
        step(0, 32'h0, 0, 1, 0, 32'h0);
        step(0, 32'h0, 0, 0, 0, 32'h0);
        // R8: snoop while idle; R9: noise on a_in afterwards
        step(0, 32'h0, 0, 0, 1, 32'h5A5A_0F0F);
        step(0, 32'h0, 0, 0, 0, 32'hFFFF_FFFF);
        step(0, 32'h0, 0, 0, 0, 32'h1111_2222);
        // R9: other strobe coinciding with own start is not captured
        step(1, 32'h4444_0000, 0, 0, 0, 32'h0);
        step(0, 32'h0, 0, 0, 1, 32'h7777_7777);
        step(0, 32'h0, 0, 1, 1, 32'h8888_8888);
        step(0, 32'h0, 0, 0, 0, 32'h0);
        step(0, 32'h0, 0, 0, 0, 32'h0);

        // Randomised traffic with occasional mid-run reset (R10)
        for (int i = 0; i < 3000; i++) begin
            logic rv, rb, ak, ti;
            rv = ($urandom % 3) == 0;
            rb = $urandom % 2;
            ak = (m_st != 0) && (($urandom % 3) == 0);
            ti = ($urandom % 5) == 0;
            if (i % 700 == 350) begin
                @(negedge clk);
                compare_all();
                rst = 1'b1;
                repeat (3) begin
                    @(negedge clk);
                    compare_all();
                end
                rst = 1'b0;
            end
            step(rv, $urandom, rb, ak, ti, $urandom);
        end
        step(0, 32'h0, 0, 0, 0, 32'h0);
        step(0, 32'h0, 0, 0, 0, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule